// File: doc/BRIEF.md
# SPI Serial Clock Divider

This block derives the serial clock of an SPI master from the core clock. A 16-bit divide field is written through a simple register port. The block clears the field's low bit to get the effective divisor, so every division is even. A field value of zero or one selects the longest period, 65536 core cycles. The serial clock has a 50% duty cycle: it changes level once every half of the effective divisor. The fastest setting, 2, toggles the serial clock on every core cycle, which gives half the core frequency.

The transfer logic raises `enable` to run the clock. While `enable` is low, the internal counter stays at zero and the serial clock rests low. Alongside the clock, the block drives one-cycle strobes that mark each rising and each falling edge, so the shift logic can launch and capture data without its own edge detector. A divide value written while the clock runs takes effect only at the next level change. The half-period in progress always finishes at its old length.

Top module: `sck_divider`

## Requirements
- R1: After a write, `rd_data` returns the 16-bit value exactly as written, including bit 0, from the cycle after the write edge onward.
- R2: The effective divisor is the field with bit 0 cleared. Each half-period lasts divisor/2 core cycles, so an odd field value gives the same timing as the even value one below it.
- R3: Field values 0 and 1 both give a divisor of 65536, which is a half-period of 32768 core cycles.
- R4: Field value 2 makes `sclk` change level on every enabled core cycle, giving half the core clock frequency.
- R5: The high phase and the low phase of `sclk` are each exactly divisor/2 core cycles long (50% duty).
- R6: While `enable` is sampled low, `sclk` is low and both strobes are low. Once `enable` is sampled high, the first rising edge of `sclk` appears divisor/2 clock edges later, counting the first edge that samples `enable` high.
- R7: `rise_stb` is high for exactly the one cycle in which `sclk` first reads high after a low phase. `fall_stb` is high for exactly the one cycle in which `sclk` first reads low after a high phase. The two strobes are never high together.
- R8: A divide value written while `enable` is high leaves the half-period in progress unchanged and takes effect from the next level change of `sclk`.
- R9: When `enable` drops while `sclk` is high, `sclk` returns low on the next edge and `fall_stb` is not asserted.
- R10: After reset, `rd_data` is 0 and `sclk`, `rise_stb` and `fall_stb` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe for the divide field |
| wr_data | input | 16 | Divide field value to store |
| rd_data | output | 16 | Stored divide field, as written |
| enable | input | 1 | Run request from the transfer logic |
| sclk | output | 1 | Serial clock, idles low |
| rise_stb | output | 1 | One-cycle pulse with each rising edge of sclk |
| fall_stb | output | 1 | One-cycle pulse with each falling edge of sclk |

## Verification
The bench sweeps every field value from 2 to 40 and measures the first-edge delay and the high and low phase lengths. This catches a design that honours bit 0 or is off by one in its counter terminal count. It runs values 0 and 1 in full to 32768-cycle half-periods, which exposes a design that treats zero as a divide by zero or by one. A divisor rewritten in the middle of a high phase must not shorten that phase; a design that loads the new value at once would cut the pulse short. Dropping `enable` during a high phase must pull `sclk` low with no falling strobe. A design that re-enabled with a stale count would also place the next first edge early.

// File: rtl/sck_div_pkg.sv
package sck_div_pkg;

   // Level of the generated serial clock
   typedef enum logic {
      SCK_LOW  = 1'b0,
      SCK_HIGH = 1'b1
   } sck_level_e;

   // Default width of the divide field
   localparam int unsigned SCK_DIV_W_DEF = 16;

endpackage

// File: rtl/sck_div_cfg.sv
// Divide-field register and sanitiser: stores the field as written and
// derives (half-period - 1) with the low bit ignored and zero widened.
module sck_div_cfg #(
   parameter int unsigned DIV_W   = 16,
   parameter int unsigned RST_DIV = 0,
   localparam int unsigned HALF_W = DIV_W - 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DIV_W-1:0]  wr_data,
   output logic [DIV_W-1:0]  field_q,
   output logic [HALF_W-1:0] half_m1
);

   logic [HALF_W-1:0] half_raw;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         field_q <= DIV_W'(RST_DIV);
      end else if (wr_en) begin
         field_q <= wr_data;
      end
   end

   // Dropping bit 0 halves the even divisor directly
   assign half_raw = field_q[DIV_W-1:1];

   // A zero half stands for the widest divisor: all ones encodes 2**HALF_W
   always_comb begin
      if (half_raw == '0) begin
         half_m1 = '1;
      end else begin
         half_m1 = half_raw - HALF_W'(1);
      end
   end

endmodule

// File: rtl/sck_half_timer.sv
// Half-period counter. The active limit is reloaded only while idle or at
// a half-period boundary, so a mid-phase rewrite never shortens a phase.
module sck_half_timer #(
   parameter int unsigned HALF_W = 15
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enable,
   input  logic [HALF_W-1:0] half_m1_next,
   output logic              terminal
);

   logic [HALF_W-1:0] cnt_q;
   logic [HALF_W-1:0] lim_q;
   logic              at_lim;

   assign at_lim   = (cnt_q == lim_q);
   assign terminal = enable && at_lim;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         lim_q <= '1;
      end else if (!enable) begin
         cnt_q <= '0;
         lim_q <= half_m1_next;
      end else if (at_lim) begin
         cnt_q <= '0;
         lim_q <= half_m1_next;
      end else begin
         cnt_q <= cnt_q + HALF_W'(1);
      end
   end

endmodule

// File: rtl/sck_wave.sv
// Serial clock level and edge strobes, all registered together.
module sck_wave
   import sck_div_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic enable,
   input  logic terminal,
   output logic sclk,
   output logic rise_stb,
   output logic fall_stb
);

   sck_level_e level_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         level_q  <= SCK_LOW;
         rise_stb <= 1'b0;
         fall_stb <= 1'b0;
      end else if (!enable) begin
         level_q  <= SCK_LOW;
         rise_stb <= 1'b0;
         fall_stb <= 1'b0;
      end else begin
         rise_stb <= terminal && (level_q == SCK_LOW);
         fall_stb <= terminal && (level_q == SCK_HIGH);
         if (terminal) begin
            level_q <= (level_q == SCK_HIGH) ? SCK_LOW : SCK_HIGH;
         end
      end
   end

   assign sclk = (level_q == SCK_HIGH);

endmodule

// File: rtl/sck_divider.sv
// Top: programmable even divider producing the SPI serial clock.
module sck_divider #(
   parameter int unsigned DIV_W   = sck_div_pkg::SCK_DIV_W_DEF,
   parameter int unsigned RST_DIV = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [DIV_W-1:0] wr_data,
   output logic [DIV_W-1:0] rd_data,
   input  logic             enable,
   output logic             sclk,
   output logic             rise_stb,
   output logic             fall_stb
);

   localparam int unsigned HALF_W = DIV_W - 1;

   // Elaboration-time parameter checks
   generate
      if (DIV_W < 2 || DIV_W > 24) begin : g_bad_width
         $error("sck_divider: DIV_W must lie in 2..24");
      end
      if (RST_DIV >= (1 << DIV_W)) begin : g_bad_reset
         $error("sck_divider: RST_DIV does not fit DIV_W bits");
      end
   endgenerate

   logic [HALF_W-1:0] half_m1;
   logic              terminal;

   sck_div_cfg #(
      .DIV_W   (DIV_W),
      .RST_DIV (RST_DIV)
   ) cfg_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_data (wr_data),
      .field_q (rd_data),
      .half_m1 (half_m1)
   );

   sck_half_timer #(
      .HALF_W (HALF_W)
   ) timer_i (
      .clk          (clk),
      .rst_n        (rst_n),
      .enable       (enable),
      .half_m1_next (half_m1),
      .terminal     (terminal)
   );

   sck_wave wave_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .enable   (enable),
      .terminal (terminal),
      .sclk     (sclk),
      .rise_stb (rise_stb),
      .fall_stb (fall_stb)
   );

endmodule

// File: rtl/sck_divider_chk.sv
// Protocol checker bound to the divider top.
module sck_divider_chk #(
   parameter int unsigned DIV_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             wr_en,
   input logic [DIV_W-1:0] wr_data,
   input logic [DIV_W-1:0] rd_data,
   input logic             enable,
   input logic             sclk,
   input logic             rise_stb,
   input logic             fall_stb
);

   // R1: the stored value is returned unchanged after a write
   a_r1_readback: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> (rd_data == $past(wr_data)));

   // R6: an idle request parks the clock low with no strobes
   a_r6_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |=> (!sclk && !rise_stb && !fall_stb));

   // R7: the strobes are mutually exclusive
   a_r7_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
      !(rise_stb && fall_stb));

   // R7: a rising strobe accompanies a low-to-high change of sclk
   a_r7_rise_marks_edge: assert property (@(posedge clk) disable iff (!rst_n)
      rise_stb |-> (sclk && !$past(sclk)));

   // R7: a falling strobe accompanies a high-to-low change of sclk
   a_r7_fall_marks_edge: assert property (@(posedge clk) disable iff (!rst_n)
      fall_stb |-> (!sclk && $past(sclk)));

   // R7: every rise of sclk is flagged
   a_r7_rise_flagged: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sclk) |-> rise_stb);

   // R9: losing enable in a high phase gives no falling strobe
   a_r9_drop_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (sclk && !enable) |=> !fall_stb);

endmodule

bind sck_divider sck_divider_chk #(.DIV_W(DIV_W)) chk_i (
   .clk      (clk),
   .rst_n    (rst_n),
   .wr_en    (wr_en),
   .wr_data  (wr_data),
   .rd_data  (rd_data),
   .enable   (enable),
   .sclk     (sclk),
   .rise_stb (rise_stb),
   .fall_stb (fall_stb)
);

// File: tb/sck_divider_tb_top.sv
module sck_divider_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [15:0] wr_data = '0;
   logic [15:0] rd_data;
   logic        enable = 1'b0;
   logic        sclk;
   logic        rise_stb;
   logic        fall_stb;

   int unsigned n_checks = 0;
   int unsigned n_errors = 0;
   bit          done = 1'b0;

   always #4 clk = ~clk; // 125 MHz

   sck_divider #(.DIV_W(16), .RST_DIV(0)) dut_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .wr_data  (wr_data),
      .rd_data  (rd_data),
      .enable   (enable),
      .sclk     (sclk),
      .rise_stb (rise_stb),
      .fall_stb (fall_stb)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_errors++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   function automatic int half_of(input logic [15:0] v);
      return ((v >> 1) == 0) ? 32768 : int'(v >> 1);
   endfunction

   task automatic write_div(input logic [15:0] v);
      @(negedge clk);
      wr_en   = 1'b1;
      wr_data = v;
      @(negedge clk);
      wr_en   = 1'b0;
   endtask

   // Count edges until the strobe selected by want_rise appears; returns count
   task automatic count_to(input bit want_rise, input int limit,
                           output int n, output bit level_ok);
      n = 0;
      level_ok = 1'b1;
      forever begin
         @(posedge clk);
         #1;
         n++;
         if (want_rise ? rise_stb : fall_stb) break;
         // still in the previous phase: level must not have changed
         if (sclk != !want_rise) level_ok = 1'b0;
         if (n > limit) break;
      end
   endtask

   task automatic measure(input logic [15:0] v, input bit full);
      int  h;
      int  n;
      bit  lvl;
      string rq;
      h  = half_of(v);
      rq = (h == 32768) ? "R3" : ((h == 1) ? "R4" : "R2");
      write_div(v);
      check(rd_data == v, "R1", $sformatf("readback of %0d", v), rd_data, v);
      @(negedge clk);
      enable = 1'b1;
      count_to(1'b1, h + 2, n, lvl);
      check(n == h, "R6", $sformatf("first rise delay v=%0d (%s)", v, rq), n, h);
      check(sclk == 1'b1 && fall_stb == 1'b0, "R7",
            $sformatf("sclk high with rise strobe v=%0d", v), sclk, 1);
      count_to(1'b0, h + 2, n, lvl);
      check(n == h && lvl, "R5", $sformatf("high phase v=%0d (%s)", v, rq), n, h);
      if (full) begin
         count_to(1'b1, h + 2, n, lvl);
         check(n == h && lvl, "R5", $sformatf("low phase v=%0d (%s)", v, rq), n, h);
      end
      @(negedge clk);
      enable = 1'b0;
      @(posedge clk);
      #1;
      check(!sclk && !rise_stb && !fall_stb, "R6",
            $sformatf("idle after disable v=%0d", v), sclk, 0);
   endtask

   initial begin : watchdog
      repeat (195000) @(posedge clk);
      if (!done) begin
         n_errors++;
         n_checks++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
         $finish;
      end
   end

   initial begin : stim
      int  n;
      bit  lvl;
      int  quiet;
      repeat (3) @(negedge clk);
      #1;
      check(rd_data == 16'd0, "R10", "reset readback", rd_data, 0);
      check(!sclk && !rise_stb && !fall_stb, "R10", "reset outputs", sclk, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // R2 / R4 / R5: sweep small field values, odd ones included
      for (int v = 2; v <= 40; v++) begin
         measure(16'(v), 1'b1);
      end

      // R1: exact readback of odd and wide patterns
      write_div(16'hA5A5);
      check(rd_data == 16'hA5A5, "R1", "readback A5A5", rd_data, 16'hA5A5);
      write_div(16'hFFFF);
      check(rd_data == 16'hFFFF, "R1", "readback FFFF", rd_data, 16'hFFFF);

      // R8: rewrite during a high phase
      write_div(16'd10);
      @(negedge clk);
      enable = 1'b1;
      count_to(1'b1, 12, n, lvl);
      check(n == 5, "R8", "rise before rewrite", n, 5);
      @(posedge clk);
      @(negedge clk);
      wr_en = 1'b1;
      wr_data = 16'd4;
      @(negedge clk);
      wr_en = 1'b0;
      // two edges of the high phase already passed since the rise
      count_to(1'b0, 12, n, lvl);
      check(n + 2 == 5 && lvl, "R8", "old high phase kept", n + 2, 5);
      count_to(1'b1, 12, n, lvl);
      check(n == 2 && lvl, "R8", "new low phase", n, 2);
      count_to(1'b0, 12, n, lvl);
      check(n == 2 && lvl, "R8", "new high phase", n, 2);

      // R9: drop enable in the middle of a high phase
      count_to(1'b1, 12, n, lvl);
      @(negedge clk);
      enable = 1'b0;
      @(posedge clk);
      #1;
      check(!sclk, "R9", "sclk low after drop", sclk, 0);
      check(!fall_stb, "R9", "no fall strobe on drop", fall_stb, 0);
      quiet = 1;
      for (int i = 0; i < 12; i++) begin
         @(posedge clk);
         #1;
         if (sclk || rise_stb || fall_stb) quiet = 0;
      end
      check(quiet == 1, "R6", "held idle while disabled", quiet, 1);
      @(negedge clk);
      enable = 1'b1;
      count_to(1'b1, 12, n, lvl);
      check(n == 2, "R6", "first rise after re-enable", n, 2);
      @(negedge clk);
      enable = 1'b0;
      @(negedge clk);

      // R3: widest divisor from field values 0 and 1
      measure(16'd0, 1'b0);
      measure(16'd1, 1'b0);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end

endmodule